// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block turns one register access on an I2C slave into the series of byte-level commands that an I2C master engine executes. The master engine handles bit timing, start and stop conditions and clock stretching. Above it, the sequencer issues start, byte-write, byte-read and stop commands one at a time, and for each command it waits for the engine's response.

A request carries:
- a 7-bit device address;
- a register address of 8 or 16 bits;
- write data of 8 or 16 bits;
- a direction flag.

Two mode inputs select the width of the register address and the width of the register data.

A write sends the device address, then the register address, then the data, and closes with a stop. A read has two phases. First it sends the device address and register address in write direction with no stop. It then issues a repeated start, re-addresses the device for reading and fetches the data bytes. The transaction ends with a stop.

On completion the block pulses `done`, together with a result code and the assembled read value. The result code records in which phase the slave refused a byte.

Top module: `i2c_regseq`

## Requirements
- R1: A read issues, in order:
  1. start;
  2. the device write address;
  3. the register address bytes;
  4. a second start (repeated start, with no stop before it);
  5. the device read address;
  6. the data reads;
  7. stop.
- R2: A write issues, in order: start, the device write address, the register address bytes, the data bytes, then stop.
- R3: Command encoding on `cmd_op`: 0 start, 1 write byte, 2 read byte, 3 stop. The device address byte is `{dev, rw}`, where rw is 0 for the write direction and 1 for the read direction. `cmd_byte` is 0 on all commands other than write byte.
- R4: `req_addr16`=1 sends two register address bytes, high byte first; otherwise only the low byte is sent. `req_data16`=1 transfers two data bytes, high byte first; otherwise only the low byte is transferred.
- R5: Read bytes are assembled most significant first. Every read byte except the last has `cmd_mack`=0 (acknowledge); the last has `cmd_mack`=1 (not-acknowledge). With 8-bit data the upper byte of `rdata` is zero.
- R6: In a read, a not-acknowledge on any written byte gives result 1 (device NACK).
- R7: In a write, a not-acknowledge on the device address gives result 1, and one on any later byte gives result 2 (incomplete). A write with every byte acknowledged gives result 0. Result 3 never occurs.
- R8: After a not-acknowledge the next command is stop, and no further bytes are sent.
- R9: The bus side of the block:
  - `busy` is high from the cycle after an accepted request until `done`;
  - `done` is a one-cycle pulse, with `busy` already low;
  - a request presented while busy is ignored;
  - `cmd_valid` is low while idle.
- R10: `cmd_valid` and the command fields stay stable until the cycle in which `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start an operation (taken when idle) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr16 | input | 1 | 16-bit register address |
| req_data16 | input | 1 | 16-bit register data |
| req_dev | input | 7 | Slave device address |
| req_reg | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 success, 1 device NACK, 2 incomplete |
| rdata | output | 16 | Read value |
| cmd_valid | output | 1 | Command to master valid |
| cmd_op | output | 2 | Command code |
| cmd_byte | output | 8 | Byte to write |
| cmd_mack | output | 1 | Acknowledge bit the master sends after a read byte |
| rsp_valid | input | 1 | Master finished the current command |
| rsp_nack | input | 1 | Slave did not acknowledge the written byte |
| rsp_data | input | 8 | Byte read from the slave |

## Verification
The block has no parameters, so the bench builds it as it stands and drives the two width inputs through all four address and data shapes. It injects not-acknowledges at the device address, at a register byte, at the re-address byte of a read and at the data bytes of a write. This reaches every result code and every shortened command stream. The master's response latency varies from zero to three cycles, which exercises the hold behaviour of the command port.

// File: rtl/i2c_regseq.sv
module i2c_regseq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_addr16,
  input  logic        req_data16,
  input  logic [6:0]  req_dev,
  input  logic [15:0] req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result,
  output logic [15:0] rdata,
  output logic        cmd_valid,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  output logic        cmd_mack,
  input  logic        rsp_valid,
  input  logic        rsp_nack,
  input  logic [7:0]  rsp_data
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEV, S_REGH, S_REGL, S_RSTART, S_DEVR, S_DATH, S_DATL, S_STOP
  } st_t;

  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;
  localparam logic [1:0] RES_OK = 2'd0, RES_DEVN = 2'd1, RES_INC = 2'd2;

  st_t         st;
  logic        wr_q, a16_q, d16_q;
  logic [6:0]  dev_q;
  logic [15:0] reg_q, wd_q;
  logic [1:0]  fail_code;

  assign busy      = (st != S_IDLE);
  assign cmd_valid = busy;
  assign fail_code = wr_q ? RES_INC : RES_DEVN;

  always_comb begin
    cmd_op   = OP_START;
    cmd_byte = 8'h00;
    cmd_mack = 1'b0;
    case (st)
      S_DEV:   begin cmd_op = OP_WR; cmd_byte = {dev_q, 1'b0}; end
      S_REGH:  begin cmd_op = OP_WR; cmd_byte = reg_q[15:8]; end
      S_REGL:  begin cmd_op = OP_WR; cmd_byte = reg_q[7:0]; end
      S_DEVR:  begin cmd_op = OP_WR; cmd_byte = {dev_q, 1'b1}; end
      S_DATH:  if (wr_q) begin cmd_op = OP_WR; cmd_byte = wd_q[15:8]; end
               else cmd_op = OP_RD;
      S_DATL:  if (wr_q) begin cmd_op = OP_WR; cmd_byte = wd_q[7:0]; end
               else begin cmd_op = OP_RD; cmd_mack = 1'b1; end
      S_STOP:  cmd_op = OP_STOP;
      default: cmd_op = OP_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      result <= RES_OK;
      rdata  <= 16'h0;
      wr_q   <= 1'b0;
      a16_q  <= 1'b0;
      d16_q  <= 1'b0;
      dev_q  <= 7'h0;
      reg_q  <= 16'h0;
      wd_q   <= 16'h0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          wr_q   <= req_write;
          a16_q  <= req_addr16;
          d16_q  <= req_data16;
          dev_q  <= req_dev;
          reg_q  <= req_reg;
          wd_q   <= req_wdata;
          rdata  <= 16'h0;
          result <= RES_OK;
          st     <= S_START;
        end
      end else if (rsp_valid) begin
        case (st)
          S_START:  st <= S_DEV;
          S_DEV:    if (rsp_nack) begin result <= RES_DEVN; st <= S_STOP; end
                    else st <= a16_q ? S_REGH : S_REGL;
          S_REGH:   if (rsp_nack) begin result <= fail_code; st <= S_STOP; end
                    else st <= S_REGL;
          S_REGL:   if (rsp_nack) begin result <= fail_code; st <= S_STOP; end
                    else if (!wr_q) st <= S_RSTART;
                    else st <= d16_q ? S_DATH : S_DATL;
          S_RSTART: st <= S_DEVR;
          S_DEVR:   if (rsp_nack) begin result <= RES_DEVN; st <= S_STOP; end
                    else st <= d16_q ? S_DATH : S_DATL;
          S_DATH:   if (!wr_q) begin rdata[15:8] <= rsp_data; st <= S_DATL; end
                    else if (rsp_nack) begin result <= RES_INC; st <= S_STOP; end
                    else st <= S_DATL;
          S_DATL:   begin
                      if (!wr_q) rdata[7:0] <= rsp_data;
                      else if (rsp_nack) result <= RES_INC;
                      st <= S_STOP;
                    end
          S_STOP:   begin st <= S_IDLE; done <= 1'b1; end
          default:  st <= S_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !cmd_valid);

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !rsp_valid |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_mack));

  p_done_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && rsp_valid && cmd_op == OP_STOP));

  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> result != 2'd3);

  p_read_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_q |-> result != RES_INC);

endmodule

// File: tb/test_i2c_regseq.sv
`timescale 1ns/1ps
module test_i2c_regseq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_write, req_addr16, req_data16;
  logic [6:0] req_dev;
  logic [15:0] req_reg, req_wdata;
  logic busy, done, cmd_valid, cmd_mack, rsp_valid, rsp_nack;
  logic [1:0] result, cmd_op;
  logic [15:0] rdata;
  logic [7:0] cmd_byte, rsp_data;

  i2c_regseq i_i2c_regseq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr16(req_addr16), .req_data16(req_data16), .req_dev(req_dev),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .result(result), .rdata(rdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_mack(cmd_mack), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_data(rsp_data));

  int checks = 0, fails = 0;
  int q_op[$], q_byte[$], q_mack[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int op, int b, int m);
    q_op.push_back(op); q_byte.push_back(b); q_mack.push_back(m);
  endtask

  task automatic run_op(bit wr, bit a16, bit d16, logic [6:0] dev, logic [15:0] rg,
                        logic [15:0] wd, logic [15:0] rd, int nack_at, int lat,
                        bit poke, string tag);
    int widx = 0, rcnt = 0, exp_res = 0;
    bit fin = 0;
    q_op.delete(); q_byte.delete(); q_mack.delete();
    push(0, 0, 0);
    push(1, {dev, 1'b0}, 0);
    if (a16) push(1, rg[15:8], 0);
    push(1, rg[7:0], 0);
    if (!wr) begin
      push(0, 0, 0);
      push(1, {dev, 1'b1}, 0);
      if (d16) push(2, 0, 0);
      push(2, 0, 1);
    end else begin
      if (d16) push(1, wd[15:8], 0);
      push(1, wd[7:0], 0);
    end
    push(3, 0, 0);

    @(negedge clk);
    req_write = wr; req_addr16 = a16; req_data16 = d16;
    req_dev = dev; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, {tag, " R9"}, "busy after request", busy, 1);
    if (poke) begin
      req_write = ~wr; req_dev = ~dev; req_reg = ~rg; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end

    while (!fin) begin
      int eop, eb, em;
      bit nk;
      while (!cmd_valid) @(negedge clk);
      if (q_op.size() == 0) begin
        chk(0, {tag, " R8"}, "extra command", cmd_op, 3);
        eop = 3; eb = 0; em = 0;
      end else begin
        eop = q_op.pop_front(); eb = q_byte.pop_front(); em = q_mack.pop_front();
      end
      chk(cmd_op == eop[1:0], {tag, " R1 R2"}, "cmd_op", cmd_op, eop);
      chk(cmd_byte == eb[7:0], {tag, " R3 R4"}, "cmd_byte", cmd_byte, eb);
      chk(cmd_mack == em[0], {tag, " R5"}, "cmd_mack", cmd_mack, em);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(cmd_valid && cmd_op == eop[1:0] && cmd_byte == eb[7:0] && cmd_mack == em[0],
            {tag, " R10"}, "command held", {cmd_valid, cmd_op, cmd_byte}, {1'b1, eop[1:0], eb[7:0]});
      end
      nk = (eop == 1) && (widx == nack_at);
      rsp_valid = 1'b1;
      rsp_nack = nk;
      rsp_data = 8'h00;
      if (eop == 2) begin
        rsp_data = (d16 && rcnt == 0) ? rd[15:8] : rd[7:0];
        rcnt++;
      end
      if (nk) begin
        exp_res = (widx == 0 || !wr) ? 1 : 2;
        q_op.delete(); q_byte.delete(); q_mack.delete();
        push(3, 0, 0);
      end
      if (eop == 1) widx++;
      if (eop == 3) fin = 1;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_data = 8'h00;
    end

    chk(done == 1'b1, {tag, " R9"}, "done pulse", done, 1);
    chk(busy == 1'b0, {tag, " R9"}, "busy low at done", busy, 0);
    chk(result == exp_res[1:0], {tag, (wr ? " R7" : " R6")}, "result", result, exp_res);
    chk(q_op.size() == 0, {tag, " R8"}, "commands left", q_op.size(), 0);
    if (!wr && exp_res == 0)
      chk(rdata == (d16 ? rd : {8'h00, rd[7:0]}), {tag, " R5"}, "rdata", rdata,
          d16 ? rd : {8'h00, rd[7:0]});
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9"}, "done one cycle", done, 0);
    chk(cmd_valid == 1'b0, {tag, " R9"}, "idle quiet", cmd_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr16 = 1'b0; req_data16 = 1'b0;
    req_dev = 7'h0; req_reg = 16'h0; req_wdata = 16'h0;
    rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_data = 8'h0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && cmd_valid == 1'b0, "R9", "reset state",
        {busy, done, cmd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(1, 0, 0, 7'h3c, 16'h0012, 16'h00a5, 16'h0, -1, 1, 0, "wr a8d8");
    run_op(1, 1, 1, 7'h51, 16'h1234, 16'hbeef, 16'h0, -1, 0, 0, "wr a16d16");
    run_op(0, 0, 0, 7'h2a, 16'h0077, 16'h0, 16'h00c3, -1, 2, 0, "rd a8d8");
    run_op(0, 1, 1, 7'h19, 16'habcd, 16'h0, 16'h5a96, -1, 3, 1, "rd a16d16 poke");
    run_op(1, 0, 1, 7'h40, 16'h0009, 16'h1357, 16'h0, 0, 1, 0, "wr devnack");
    run_op(1, 1, 1, 7'h40, 16'h0102, 16'h2468, 16'h0, 3, 2, 0, "wr data-hi nack");
    run_op(1, 0, 1, 7'h40, 16'h0033, 16'h9999, 16'h0, 3, 0, 0, "wr last nack");
    run_op(0, 0, 0, 7'h61, 16'h0044, 16'h0, 16'h00ff, 2, 1, 0, "rd re-addr nack");
    run_op(0, 1, 0, 7'h61, 16'h5566, 16'h0, 16'h0011, 2, 0, 0, "rd reg-lo nack");
    run_op(0, 1, 0, 7'h7f, 16'hfedc, 16'h0, 16'h8142, -1, 1, 0, "rd a16d8");
    run_op(0, 0, 1, 7'h01, 16'h0080, 16'h0, 16'h0f0e, 0, 1, 0, "rd devnack");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule